// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block produces the two comparison pulses that feed a PLL phase detector. On the feedback side, a fast divider clock passes through a digital model of a dual-modulus prescaler. That prescaler divides by P+1 while a swallow counter is nonzero and by P after it reaches zero. A main counter counts prescaler cycles and ends the feedback period after N of them. One feedback period is therefore P×N+A divider-clock cycles. On the reference side, a separate counter divides the oscillator clock by R.

A single select input picks the prescaler base. Select high gives the smaller base (64 by default) and select low gives the larger one (128 by default). Both bases are parameters, so the same block covers the lower-frequency variant with bases 32 and 64.

Programmed values are sampled into working registers in two cases: while the side is disabled, and at the end of each output period. A new setting therefore never cuts a period short. An illegal setting is flagged, and the divider keeps running on the last legal one.

Top module: `swallow_divider`

## Requirements
- R1: With enable held high, `fp` pulses once every P×N+A enabled `vcoClk` edges, where P is `PRE_SMALL` when the select is 1 and `PRE_LARGE` when it is 0.
- R2: The swallow count stretches exactly A of the N prescaler cycles by one clock. A=0 gives P×N, and A=N-1 gives P×N+N-1.
- R3: With enable high, `fr` pulses once every R enabled `oscClk` edges.
- R4: `fp` and `fr` are each high for exactly one cycle of their own clock.
- R5: A change of swallow count, main count, select or reference count made during a period does not alter that period. It takes effect from the next period.
- R6: When main count is below 3, or when swallow count is greater than or equal to main count, `progErr` is high from the next `vcoClk` edge. The feedback divider keeps the last legal setting while the error lasts.
- R7: When reference count is below 3, `refErr` is high from the next `oscClk` edge, and the reference divider keeps the last legal R.
- R8: While an enable is low, its pulse output stays low and its counters are parked. The first pulse after enable rises arrives one full period later.
- R9: While reset is asserted, `fp`, `fr`, `progErr` and `refErr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vcoClk | input | 1 | Divider (prescaler input) clock |
| oscClk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| fbEn | input | 1 | Feedback divider enable (vcoClk domain) |
| refEn | input | 1 | Reference divider enable (oscClk domain) |
| divSel | input | 1 | Prescaler base select: 1 = small, 0 = large |
| swallowIn | input | 7 | Programmed swallow count A |
| mainIn | input | 11 | Programmed main count N |
| refIn | input | 14 | Programmed reference count R |
| fp | output | 1 | Feedback comparison pulse |
| fr | output | 1 | Reference comparison pulse |
| progErr | output | 1 | Illegal feedback setting flag |
| refErr | output | 1 | Illegal reference setting flag |

## Verification
The bench targets the boundaries of the swallow logic. It covers A=0, A=N-1 at the minimum N=3, and a switch of prescaler base. A design that ends the stretched phase one prescaler cycle early or late would show a period that is off by one cycle. The bench also rewrites the settings in the middle of a period. A design that reloads at once, instead of at the period end, would emit a short or long pulse spacing. Illegal main, swallow and reference values are applied while the dividers run, which catches a design that adopts the bad value or never raises its flag. The reference is also run at its largest count, so a counter truncated to fewer than 14 bits would wrap and fire early.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

  localparam int MIN_RATIO = 3;

  // strobes from feedback control to feedback datapath
  typedef struct packed {
    logic park;      // side disabled: hold counters at start of period
    logic pscWrap;   // current prescaler cycle ends this edge
    logic mainStep;  // count one prescaler cycle off the main counter
    logic reload;    // period ends this edge: emit pulse, reload counters
    logic useInput;  // programmed values are legal and may be adopted
  } fbStrobe_t;

endpackage

// File: rtl/swallow_fb_ctrl.sv
module swallow_fb_ctrl
  import swallow_div_pkg::*;
#(
  parameter int A_W = 7,
  parameter int N_W = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           en,
  input  logic [A_W-1:0] swallowIn,
  input  logic [N_W-1:0] mainIn,
  input  logic           pscLast,
  input  logic           mainLast,
  output fbStrobe_t      strb,
  output logic           errFlag
);

  localparam logic [N_W-1:0] N_MIN = N_W'(MIN_RATIO);

  logic cfgOk;
  logic errQ;

  // legality: N at least the minimum, A strictly below N
  always_comb begin
    cfgOk = (mainIn >= N_MIN) && (N_W'(swallowIn) < mainIn);
  end

  always_comb begin
    strb          = '0;
    strb.useInput = cfgOk;
    strb.park     = !en;
    strb.pscWrap  = en && pscLast;
    strb.reload   = en && pscLast && mainLast;
    strb.mainStep = en && pscLast && !mainLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= !cfgOk;
  end

  assign errFlag = errQ;

endmodule

// File: rtl/swallow_fb_path.sv
module swallow_fb_path
  import swallow_div_pkg::*;
#(
  parameter int PRE_SMALL = 64,
  parameter int PRE_LARGE = 128,
  parameter int A_W       = 7,
  parameter int N_W       = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  fbStrobe_t      strb,
  input  logic           selIn,
  input  logic [A_W-1:0] swallowIn,
  input  logic [N_W-1:0] mainIn,
  output logic           pscLast,
  output logic           mainLast,
  output logic           pulse
);

  localparam int PSC_W = $clog2(PRE_LARGE + 1);
  localparam logic [PSC_W-1:0] SMALL_M = PSC_W'(PRE_SMALL);
  localparam logic [PSC_W-1:0] LARGE_M = PSC_W'(PRE_LARGE);
  localparam logic [N_W-1:0]   N_RST   = N_W'(MIN_RATIO);

  // working setting
  logic [A_W-1:0]   cfgA;
  logic [N_W-1:0]   cfgN;
  logic             cfgSel;
  // counters
  logic [PSC_W-1:0] pscCnt;
  logic [N_W-1:0]   mainLeft;
  logic [A_W-1:0]   swLeft;
  logic             pulseQ;

  logic [A_W-1:0]   nextA;
  logic [N_W-1:0]   nextN;
  logic             nextSel;
  logic [PSC_W-1:0] baseMod;
  logic [PSC_W-1:0] lastIdx;
  logic             loadCfg;

  always_comb begin
    nextA   = strb.useInput ? swallowIn : cfgA;
    nextN   = strb.useInput ? mainIn    : cfgN;
    nextSel = strb.useInput ? selIn     : cfgSel;
    loadCfg = strb.park || strb.reload;
  end

  // prescaler modulus: base, plus one while swallowing
  always_comb begin
    baseMod = cfgSel ? SMALL_M : LARGE_M;
    lastIdx = (swLeft != '0) ? baseMod : (baseMod - PSC_W'(1));
  end

  assign pscLast  = (pscCnt == lastIdx);
  assign mainLast = (mainLeft == N_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgA   <= '0;
      cfgN   <= N_RST;
      cfgSel <= 1'b0;
    end else if (loadCfg) begin
      cfgA   <= nextA;
      cfgN   <= nextN;
      cfgSel <= nextSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (strb.park || strb.pscWrap) begin
      pscCnt <= '0;
    end else begin
      pscCnt <= pscCnt + PSC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainLeft <= N_RST;
      swLeft   <= '0;
    end else if (loadCfg) begin
      mainLeft <= nextN;
      swLeft   <= nextA;
    end else if (strb.mainStep) begin
      mainLeft <= mainLeft - N_W'(1);
      if (swLeft != '0) swLeft <= swLeft - A_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseQ <= 1'b0;
    else       pulseQ <= strb.reload;
  end

  assign pulse = pulseQ;

endmodule

// File: rtl/swallow_ref_div.sv
module swallow_ref_div
  import swallow_div_pkg::*;
#(
  parameter int R_W = 14
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           en,
  input  logic [R_W-1:0] refIn,
  output logic           pulse,
  output logic           errFlag
);

  localparam logic [R_W-1:0] R_MIN = R_W'(MIN_RATIO);

  logic [R_W-1:0] cfgR;
  logic [R_W-1:0] refLeft;
  logic [R_W-1:0] nextR;
  logic           refOk;
  logic           endPeriod;
  logic           pulseQ;
  logic           errQ;

  always_comb begin
    refOk     = (refIn >= R_MIN);
    nextR     = refOk ? refIn : cfgR;
    endPeriod = en && (refLeft == R_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgR    <= R_MIN;
      refLeft <= R_MIN;
    end else if (!en || endPeriod) begin
      cfgR    <= nextR;
      refLeft <= nextR;
    end else begin
      refLeft <= refLeft - R_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      pulseQ <= endPeriod;
      errQ   <= !refOk;
    end
  end

  assign pulse   = pulseQ;
  assign errFlag = errQ;

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_div_pkg::*;
#(
  parameter int PRE_SMALL = 64,
  parameter int PRE_LARGE = 128,
  parameter int A_W       = 7,
  parameter int N_W       = 11,
  parameter int R_W       = 14
) (
  input  logic           vcoClk,
  input  logic           oscClk,
  input  logic           rstN,
  input  logic           fbEn,
  input  logic           refEn,
  input  logic           divSel,
  input  logic [A_W-1:0] swallowIn,
  input  logic [N_W-1:0] mainIn,
  input  logic [R_W-1:0] refIn,
  output logic           fp,
  output logic           fr,
  output logic           progErr,
  output logic           refErr
);

  fbStrobe_t fbStrb;
  logic      pscLast;
  logic      mainLast;

  swallow_fb_ctrl #(.A_W(A_W), .N_W(N_W)) uCtrl (
    .clk      (vcoClk),
    .rstN     (rstN),
    .en       (fbEn),
    .swallowIn(swallowIn),
    .mainIn   (mainIn),
    .pscLast  (pscLast),
    .mainLast (mainLast),
    .strb     (fbStrb),
    .errFlag  (progErr)
  );

  swallow_fb_path #(
    .PRE_SMALL(PRE_SMALL), .PRE_LARGE(PRE_LARGE), .A_W(A_W), .N_W(N_W)
  ) uPath (
    .clk      (vcoClk),
    .rstN     (rstN),
    .strb     (fbStrb),
    .selIn    (divSel),
    .swallowIn(swallowIn),
    .mainIn   (mainIn),
    .pscLast  (pscLast),
    .mainLast (mainLast),
    .pulse    (fp)
  );

  swallow_ref_div #(.R_W(R_W)) uRef (
    .clk    (oscClk),
    .rstN   (rstN),
    .en     (refEn),
    .refIn  (refIn),
    .pulse  (fr),
    .errFlag(refErr)
  );

endmodule

// File: rtl/swallow_divider_checker.sv
module swallow_divider_checker #(
  parameter int A_W = 7,
  parameter int N_W = 11,
  parameter int R_W = 14
) (
  input logic           vcoClk,
  input logic           oscClk,
  input logic           rstN,
  input logic           fbEn,
  input logic           refEn,
  input logic [A_W-1:0] swallowIn,
  input logic [N_W-1:0] mainIn,
  input logic [R_W-1:0] refIn,
  input logic           fp,
  input logic           fr,
  input logic           progErr,
  input logic           refErr
);

  logic fbBad;
  logic refBad;
  assign fbBad  = (mainIn < N_W'(3)) || (N_W'(swallowIn) >= mainIn);
  assign refBad = (refIn < R_W'(3));

  assert_fp_single_R4: assert property (@(posedge vcoClk) disable iff (!rstN)
    fp |=> !fp);

  assert_fr_single_R4: assert property (@(posedge oscClk) disable iff (!rstN)
    fr |=> !fr);

  assert_fp_parked_R8: assert property (@(posedge vcoClk) disable iff (!rstN)
    !fbEn |=> !fp);

  assert_fr_parked_R8: assert property (@(posedge oscClk) disable iff (!rstN)
    !refEn |=> !fr);

  assert_prog_flag_R6: assert property (@(posedge vcoClk) disable iff (!rstN)
    fbBad |=> progErr);

  assert_prog_clear_R6: assert property (@(posedge vcoClk) disable iff (!rstN)
    !fbBad |=> !progErr);

  assert_ref_flag_R7: assert property (@(posedge oscClk) disable iff (!rstN)
    refBad |=> refErr);

  assert_ref_clear_R7: assert property (@(posedge oscClk) disable iff (!rstN)
    !refBad |=> !refErr);

  always_comb begin
    if (!rstN) begin
      assert_reset_quiet_R9: assert (!fp && !fr && !progErr && !refErr);
    end
  end

endmodule

bind swallow_divider swallow_divider_checker #(
  .A_W(A_W), .N_W(N_W), .R_W(R_W)
) uChk (
  .vcoClk   (vcoClk),
  .oscClk   (oscClk),
  .rstN     (rstN),
  .fbEn     (fbEn),
  .refEn    (refEn),
  .swallowIn(swallowIn),
  .mainIn   (mainIn),
  .refIn    (refIn),
  .fp       (fp),
  .fr       (fr),
  .progErr  (progErr),
  .refErr   (refErr)
);

// File: tb/swallow_divider_test.sv
module swallow_divider_test;

  localparam int CLK_PERIOD = 10;
  localparam int OSC_PERIOD = 26;
  localparam int P_SMALL    = 64;
  localparam int P_LARGE    = 128;
  localparam int WATCHDOG   = 190000;

  logic        vcoClk = 1'b0;
  logic        oscClk = 1'b0;
  logic        rstN   = 1'b0;
  logic        fbEn   = 1'b0;
  logic        refEn  = 1'b0;
  logic        divSel = 1'b1;
  logic [6:0]  swallowIn = 7'd0;
  logic [10:0] mainIn    = 11'd5;
  logic [13:0] refIn     = 14'd7;
  logic        fp, fr, progErr, refErr;

  swallow_divider uut (
    .vcoClk(vcoClk), .oscClk(oscClk), .rstN(rstN),
    .fbEn(fbEn), .refEn(refEn), .divSel(divSel),
    .swallowIn(swallowIn), .mainIn(mainIn), .refIn(refIn),
    .fp(fp), .fr(fr), .progErr(progErr), .refErr(refErr)
  );

  always #(CLK_PERIOD/2) vcoClk = ~vcoClk;
  always #(OSC_PERIOD/2) oscClk = ~oscClk;

  int    vectors    = 0;
  int    miscompares = 0;
  string fbReq  = "R9";
  string refReq = "R9";
  bit    fbDone = 1'b0;
  bit    refDone = 1'b0;
  bit    ended = 1'b0;

  // ---------------- behavioural reference model ----------------
  int fbCnt, mN, mA, mSel;
  bit expFp, expProgErr;
  int rCnt, mR;
  bit expFr, expRefErr;

  always @(posedge vcoClk or negedge rstN) begin
    if (!rstN) begin
      fbCnt = 0; mN = 3; mA = 0; mSel = 0;
      expFp = 0; expProgErr = 0;
    end else begin
      bit legal;
      legal = (int'(mainIn) >= 3) && (int'(swallowIn) < int'(mainIn));
      expProgErr = !legal;
      if (!fbEn) begin
        fbCnt = 0; expFp = 0;
        if (legal) begin mN = mainIn; mA = swallowIn; mSel = divSel; end
      end else begin
        fbCnt++;
        if (fbCnt == (mSel ? P_SMALL : P_LARGE) * mN + mA) begin
          expFp = 1; fbCnt = 0;
          if (legal) begin mN = mainIn; mA = swallowIn; mSel = divSel; end
        end else begin
          expFp = 0;
        end
      end
    end
  end

  always @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      rCnt = 0; mR = 3; expFr = 0; expRefErr = 0;
    end else begin
      bit legal;
      legal = int'(refIn) >= 3;
      expRefErr = !legal;
      if (!refEn) begin
        rCnt = 0; expFr = 0;
        if (legal) mR = refIn;
      end else begin
        rCnt++;
        if (rCnt == mR) begin
          expFr = 1; rCnt = 0;
          if (legal) mR = refIn;
        end else begin
          expFr = 0;
        end
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge vcoClk) begin
    if (!ended) begin
      vectors += 2;
      if (fp !== expFp) begin
        miscompares++;
        $display("FAIL %s fp got %b expected %b at %0t", fbReq, fp, expFp, $time);
      end
      if (progErr !== expProgErr) begin
        miscompares++;
        $display("FAIL %s progErr got %b expected %b at %0t", fbReq, progErr, expProgErr, $time);
      end
    end
  end

  always @(negedge oscClk) begin
    if (!ended) begin
      vectors += 2;
      if (fr !== expFr) begin
        miscompares++;
        $display("FAIL %s fr got %b expected %b at %0t", refReq, fr, expFr, $time);
      end
      if (refErr !== expRefErr) begin
        miscompares++;
        $display("FAIL %s refErr got %b expected %b at %0t", refReq, refErr, expRefErr, $time);
      end
    end
  end

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic fbWait(int n);
    repeat (n) @(negedge vcoClk);
  endtask

  task automatic refWait(int n);
    repeat (n) @(negedge oscClk);
  endtask

  // ---------------- feedback stimulus ----------------
  initial begin
    fbReq = "R9";                       // R9: reset state
    fbWait(6);
    rstN = 1'b1;
    fbWait(4);
    // R1: small base, A=2, N=5 -> 64*5+2
    fbReq = "R1";
    divSel = 1'b1; mainIn = 11'd5; swallowIn = 7'd2; fbEn = 1'b1;
    fbWait(3 * 322 + 10);
    // R5: change to large base, N=4, A=0 in mid period
    fbReq = "R5";
    fbWait(100);
    divSel = 1'b0; mainIn = 11'd4; swallowIn = 7'd0;
    fbWait(3 * 512 + 300);
    // R2: boundary A=N-1 at minimum N
    fbReq = "R2";
    mainIn = 11'd3; swallowIn = 7'd2;
    fbWait(4 * 386 + 50);
    // R6: N below minimum, then A equal to N; old setting held
    fbReq = "R6";
    mainIn = 11'd2; swallowIn = 7'd0;
    fbWait(900);
    mainIn = 11'd6; swallowIn = 7'd6;
    fbWait(900);
    swallowIn = 7'd1; mainIn = 11'd4; divSel = 1'b1;
    fbWait(3 * 257 + 20);
    // R8: disable parks, restart gives a full period
    fbReq = "R8";
    fbEn = 1'b0;
    fbWait(60);
    fbEn = 1'b1;
    fbWait(2 * 257 + 20);
    // R2/R4: large base, A=N-1 with larger N
    fbReq = "R4";
    divSel = 1'b0; mainIn = 11'd10; swallowIn = 7'd9;
    fbWait(3 * 1289 + 40);
    fbDone = 1'b1;
  end

  // ---------------- reference stimulus ----------------
  initial begin
    refReq = "R9";
    wait (rstN);
    refWait(3);
    refReq = "R3";                      // R3: divide by 7
    refIn = 14'd7; refEn = 1'b1;
    refWait(40);
    refIn = 14'd3;                      // minimum legal R
    refWait(30);
    refReq = "R7";                      // R7: illegal R held off
    refIn = 14'd2;
    refWait(20);
    refIn = 14'd0;
    refWait(20);
    refReq = "R5";                      // R5: mid-period change
    refIn = 14'd100;
    refWait(250);
    refIn = 14'd40;
    refWait(150);
    refReq = "R8";                      // R8: parked reference
    refEn = 1'b0;
    refWait(30);
    refEn = 1'b1;
    refWait(100);
    refReq = "R3";                      // R3: largest R
    refIn = 14'd16383;
    refWait(16383 + 100);
    refDone = 1'b1;
  end

  initial begin
    wait (fbDone && refDone);
    fbWait(5);
    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge vcoClk);
    miscompares++;
    $display("FAIL R1 watchdog: got timeout, expected completion");
    finishRun();
  end

endmodule